// File: doc/BRIEF.md
# Jitter Test Pattern Generator

This block sits in the 125 MHz transmit path just in front of the serializer. It can replace the normal stream of 10-bit transmit code groups with a diagnostic stream. When diagnostics are off, the normal code group goes to the output unchanged and with no added cycle. When diagnostics are on, a 3-bit select chooses the source of every outgoing group:

- a user 10-bit pattern repeated on every group,
- a fixed bit-level tone (high, mixed or low frequency),
- a pseudo-random sequence.

The enable, the select code and the user pattern are captured in configuration registers on each rising clock edge. A change therefore takes effect at the next clock boundary. A change of the enable or the select code restarts both sequenced modes: the mixed-frequency pair and the pseudo-random generator. The serializer sends bit 9 of each output group first, so every pattern below is written with bit 9 as the leftmost character.

Top module: `jitter_pattern_gen`

## Requirements
- R1: While the captured enable is 0, `tx_cg_o` equals `tx_cg_i` combinationally, in the same cycle and without latency.
- R2: Reset clears the captured enable and the captured custom pattern. During reset and until an enable of 1 has been captured, the output follows `tx_cg_i`.
- R3: With select 3'b000 captured, every group is the custom pattern captured at the last rising edge.
- R4: With select 3'b001 captured, every group is 10'b1010101010.
- R5: With select 3'b010 captured, the groups alternate 10'b1111101011 and 10'b0000010100. The first group after entering the mode is 10'b1111101011.
- R6: With select 3'b011 or 3'b101 captured, every group is 10'b1111100000.
- R7: With select 3'b100 captured, the output comes from a 7-bit shift register s. Its reset and restart value is 7'h7F. Each step produces the bit n = s[6] ^ s[5] and updates s to {s[5:0], n}. Each group holds 10 steps, and the first step of the group goes to bit 9. The first group after entering the mode is computed from 7'h7F. The register never holds zero.
- R8: The reserved selects 3'b110 and 3'b111 produce 10'b1111100000 on every group.
- R9: A new enable, select or custom value changes the output only after the next rising edge. A change of the enable or the select restarts the sequences of R5 and R7 at their first group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| diag_en_i | input | 1 | Diagnostic pattern enable |
| pat_sel_i | input | 3 | Pattern select code |
| custom_pat_i | input | 10 | User 10-bit pattern |
| tx_cg_i | input | 10 | Normal transmit code group |
| tx_cg_o | output | 10 | Code group to the serializer, bit 9 sent first |

## Verification
The assertions check on every cycle the following behaviours:

- the same-cycle pass-through when the previous edge captured no enable,
- the fixed tones for the high-frequency, low-frequency and reserved codes,
- the custom pattern against the value sampled one edge earlier,
- the inversion between successive mixed-frequency groups and their first group,
- a shift register that never reaches zero.

Only the bench scenarios can show the following:

- the exact pseudo-random group sequence over more than one full period,
- that the sequences restart after a switch away and back,
- that a new setting has no effect before the edge.

// File: rtl/jpg_pkg.sv
package jpg_pkg;
  localparam int unsigned CG_W = 10;

  typedef enum logic [2:0] {
    SEL_CUSTOM  = 3'b000,
    SEL_HIGH    = 3'b001,
    SEL_MIXED   = 3'b010,
    SEL_LOW     = 3'b011,
    SEL_PRBS    = 3'b100,
    SEL_LOW_ALT = 3'b101,
    SEL_RSV_A   = 3'b110,
    SEL_RSV_B   = 3'b111
  } pat_sel_e;

  localparam logic [CG_W-1:0] PAT_HIGH  = 10'b1010101010;
  localparam logic [CG_W-1:0] PAT_MIX_A = 10'b1111101011;
  localparam logic [CG_W-1:0] PAT_MIX_B = 10'b0000010100;
  localparam logic [CG_W-1:0] PAT_LOW   = 10'b1111100000;

  typedef struct packed {
    logic            en;
    pat_sel_e        sel;
    logic [CG_W-1:0] custom;
  } diag_cfg_t;
endpackage

// File: rtl/jpg_cfg.sv
module jpg_cfg
  import jpg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [2:0]      sel_i,
  input  logic [CG_W-1:0] custom_i,
  output diag_cfg_t       cfg_o,
  output logic            restart_o,
  output logic            phase_o
);
  diag_cfg_t cfg_q;
  logic      phase_q;

  // restart when mode identity changes; custom value alone does not restart
  assign restart_o = (en_i != cfg_q.en) || (pat_sel_e'(sel_i) != cfg_q.sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '{en: 1'b0, sel: SEL_CUSTOM, custom: '0};
      phase_q <= 1'b0;
    end else begin
      cfg_q.en     <= en_i;
      cfg_q.sel    <= pat_sel_e'(sel_i);
      cfg_q.custom <= custom_i;
      phase_q      <= restart_o ? 1'b0 : ~phase_q;
    end
  end

  assign cfg_o   = cfg_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/jpg_prbs.sv
module jpg_prbs #(
  parameter int unsigned LFSR_W  = 7,
  parameter int unsigned TAP_A   = 7,
  parameter int unsigned TAP_B   = 6,
  parameter int unsigned GROUP_W = 10,
  parameter logic [LFSR_W-1:0] SEED = 7'h7F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  output logic [GROUP_W-1:0] group_o,
  output logic [LFSR_W-1:0]  state_o
);
  logic [LFSR_W-1:0]           lfsr_q;
  logic [GROUP_W:0][LFSR_W-1:0] chain;

  assign chain[0] = lfsr_q;

  for (genvar i = 0; i < GROUP_W; i++) begin : g_step
    logic nb;
    assign nb                   = chain[i][TAP_A-1] ^ chain[i][TAP_B-1];
    assign chain[i+1]           = {chain[i][LFSR_W-2:0], nb};
    assign group_o[GROUP_W-1-i] = nb;  // first generated bit leaves first
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lfsr_q <= SEED;
    else if (restart_i) lfsr_q <= SEED;
    else                lfsr_q <= chain[GROUP_W];
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/jitter_pattern_gen.sv
module jitter_pattern_gen
  import jpg_pkg::*;
#(
  parameter int unsigned LFSR_W = 7,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 7'h7F
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            diag_en_i,
  input  logic [2:0]      pat_sel_i,
  input  logic [CG_W-1:0] custom_pat_i,
  input  logic [CG_W-1:0] tx_cg_i,
  output logic [CG_W-1:0] tx_cg_o
);
  diag_cfg_t       cfg;
  logic            restart;
  logic            phase;
  logic [CG_W-1:0] prbs_grp;
  logic [LFSR_W-1:0] lfsr_q;
  logic [CG_W-1:0] diag_grp;

  jpg_cfg i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (diag_en_i),
    .sel_i     (pat_sel_i),
    .custom_i  (custom_pat_i),
    .cfg_o     (cfg),
    .restart_o (restart),
    .phase_o   (phase)
  );

  jpg_prbs #(
    .LFSR_W  (LFSR_W),
    .TAP_A   (7),
    .TAP_B   (6),
    .GROUP_W (CG_W),
    .SEED    (LFSR_SEED)
  ) i_prbs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .group_o   (prbs_grp),
    .state_o   (lfsr_q)
  );

  always_comb begin
    unique case (cfg.sel)
      SEL_CUSTOM: diag_grp = cfg.custom;
      SEL_HIGH:   diag_grp = PAT_HIGH;
      SEL_MIXED:  diag_grp = phase ? PAT_MIX_B : PAT_MIX_A;
      SEL_PRBS:   diag_grp = prbs_grp;
      default:    diag_grp = PAT_LOW;  // low tones and reserved codes
    endcase
  end

  assign tx_cg_o = cfg.en ? diag_grp : tx_cg_i;
endmodule

// File: rtl/jpg_checker.sv
module jpg_checker #(
  parameter int unsigned LFSR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              diag_en_i,
  input logic [2:0]        pat_sel_i,
  input logic [9:0]        custom_pat_i,
  input logic [9:0]        tx_cg_i,
  input logic [9:0]        tx_cg_o,
  input logic [LFSR_W-1:0] lfsr_q
);
  logic mix_now, hi_now, cust_now, low_now;
  assign mix_now  = rst_ni && diag_en_i && pat_sel_i == 3'b010;
  assign hi_now   = rst_ni && diag_en_i && pat_sel_i == 3'b001;
  assign cust_now = rst_ni && diag_en_i && pat_sel_i == 3'b000;
  assign low_now  = rst_ni && diag_en_i &&
                    (pat_sel_i == 3'b011 || pat_sel_i == 3'b101);

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!diag_en_i) |-> tx_cg_o == tx_cg_i); // R1
  AST_CUSTOM_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cust_now) |-> tx_cg_o == $past(custom_pat_i)); // R3
  AST_HIGH_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hi_now) |-> tx_cg_o == 10'b1010101010); // R4
  AST_MIX_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mix_now) && !$past(mix_now, 2)) |-> tx_cg_o == 10'b1111101011); // R5
  AST_MIX_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mix_now) && $past(mix_now, 2)) |-> tx_cg_o == ~$past(tx_cg_o)); // R5
  AST_LOW_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(low_now) |-> tx_cg_o == 10'b1111100000); // R6
  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0); // R7
  AST_RSV_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && diag_en_i && pat_sel_i[2:1] == 2'b11)
      |-> tx_cg_o == 10'b1111100000); // R8
endmodule

bind jitter_pattern_gen jpg_checker #(.LFSR_W(LFSR_W)) i_jpg_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .diag_en_i    (diag_en_i),
  .pat_sel_i    (pat_sel_i),
  .custom_pat_i (custom_pat_i),
  .tx_cg_i      (tx_cg_i),
  .tx_cg_o      (tx_cg_o),
  .lfsr_q       (lfsr_q)
);

// File: tb/test_jitter_pattern_gen.sv
module test_jitter_pattern_gen;
  localparam time CLK_P = 8ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       diag_en_i = 1'b0;
  logic [2:0] pat_sel_i = 3'b000;
  logic [9:0] custom_pat_i = '0;
  logic [9:0] tx_cg_i = '0;
  logic [9:0] tx_cg_o;

  int checks = 0;
  int failures = 0;

  jitter_pattern_gen i_jitter_pattern_gen (
    .clk_i(clk), .rst_ni(rst_ni), .diag_en_i(diag_en_i), .pat_sel_i(pat_sel_i),
    .custom_pat_i(custom_pat_i), .tx_cg_i(tx_cg_i), .tx_cg_o(tx_cg_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [9:0] exp);
    checks++;
    if (tx_cg_o !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", req, tx_cg_o, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic set_mode(input logic en, input logic [2:0] sel);
    diag_en_i = en;
    pat_sel_i = sel;
  endtask

  // reference shift register: 10 steps, first bit to bit 9
  function automatic logic [16:0] ref_grp(input logic [6:0] s);
    logic [6:0] st = s;
    logic [9:0] g;
    for (int i = 0; i < 10; i++) begin
      logic nb = st[6] ^ st[5];
      g[9-i] = nb;
      st = {st[5:0], nb};
    end
    return {st, g};
  endfunction

  task automatic t_reset();
    diag_en_i = 1'b1; pat_sel_i = 3'b001; custom_pat_i = 10'h3FF;
    tx_cg_i = 10'h155;
    step();
    chk("R2 output follows input during reset", 10'h155);
    set_mode(1'b0, 3'b000);
    rst_ni = 1'b1;
    step();
    tx_cg_i = 10'h2AA;
    #1;
    chk("R2 enable clear after reset", 10'h2AA);
  endtask

  task automatic t_pass();
    set_mode(1'b0, 3'b001);
    for (int i = 0; i < 4; i++) begin
      tx_cg_i = 10'(i * 97 + 13);
      #1;
      chk("R1 same-cycle pass-through", 10'(i * 97 + 13));
      step();
    end
  endtask

  task automatic t_custom();
    custom_pat_i = 10'h1C7;
    set_mode(1'b1, 3'b000);
    #1;
    chk("R9 no effect before edge", tx_cg_i);
    step();
    chk("R3 custom first", 10'h1C7);
    step();
    chk("R3 custom repeat", 10'h1C7);
    custom_pat_i = 10'h0F3;
    #1;
    chk("R9 custom change waits for edge", 10'h1C7);
    step();
    chk("R3 custom updated", 10'h0F3);
  endtask

  task automatic t_high();
    set_mode(1'b1, 3'b001);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 high tone", 10'b1010101010);
    end
  endtask

  task automatic t_mixed();
    set_mode(1'b1, 3'b010);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R5 mixed alternation", (i % 2 == 0) ? 10'b1111101011 : 10'b0000010100);
    end
    set_mode(1'b1, 3'b011);
    step();
    set_mode(1'b1, 3'b010);
    step();
    chk("R9 mixed restarts at first group", 10'b1111101011);
    step();
    chk("R5 mixed second after restart", 10'b0000010100);
    set_mode(1'b0, 3'b010);
    step();
    set_mode(1'b1, 3'b010);
    step();
    chk("R9 mixed restart after enable toggle", 10'b1111101011);
  endtask

  task automatic t_low();
    set_mode(1'b1, 3'b011);
    step();
    chk("R6 low tone code 011", 10'b1111100000);
    set_mode(1'b1, 3'b101);
    step();
    chk("R6 low tone code 101", 10'b1111100000);
    step();
    chk("R6 low tone repeat", 10'b1111100000);
  endtask

  task automatic t_reserved();
    set_mode(1'b1, 3'b110);
    step();
    chk("R8 reserved 110", 10'b1111100000);
    set_mode(1'b1, 3'b111);
    step();
    chk("R8 reserved 111", 10'b1111100000);
  endtask

  task automatic t_prbs();
    logic [6:0]  s = 7'h7F;
    logic [16:0] r;
    set_mode(1'b1, 3'b100);
    for (int i = 0; i < 130; i++) begin
      step();
      r = ref_grp(s);
      chk("R7 prbs group", r[9:0]);
      s = r[16:10];
    end
    set_mode(1'b1, 3'b001);
    step();
    set_mode(1'b1, 3'b100);
    step();
    r = ref_grp(7'h7F);
    chk("R9 prbs restarts from seed", r[9:0]);
    step();
    r = ref_grp(r[16:10]);
    chk("R7 prbs second after restart", r[9:0]);
  endtask

  task automatic t_disable();
    set_mode(1'b0, 3'b100);
    tx_cg_i = 10'h321;
    #1;
    chk("R9 disable waits for edge", ref_grp(ref_grp(7'h7F)[16:10])[9:0] ^ 10'h000);
    step();
    chk("R1 pass-through after disable", 10'h321);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P/4);
    t_reset();
    t_pass();
    t_custom();
    t_high();
    t_mixed();
    t_low();
    t_reserved();
    t_prbs();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule